// File: doc/BRIEF.md
# Retrodirective Element Phase Controller

This block is the digital controller of one element in a retrodirective transceiver array. On every conversion tick it reads the converter code of the receive loop's phase-delay control voltage. It turns that code into a phase through a computed lookup, subtracts a calibrated receive offset, and publishes the result as the element's received relative phase. One tick later it drives a transmit phase-shifter code so that the transmitted relative phase is the negative of that received phase, with a second calibrated offset taken out.

It can also steer by hand. In that case it drives the receive delay element through its own converter and commands any transmit phase. Each offset is captured once by a calibration sequence. When the received carrier disappears, the controller takes over the receive delay element. It then either holds the last phase or extends it by the last measured rate for a programmable number of ticks.

Phases are 10-bit unsigned codes, where 1024 codes span one full turn. All phase arithmetic wraps modulo 1024.

Top module: `phase_conj_ctrl`

## Requirements
- R1: After reset, all outputs are zero: `rx_dac_o`, `rx_drive_o`, `tx_dac_o`, `doa_o` and both `cal_done_o` bits.
- R2: In closed-loop mode with the carrier present, each tick sets `doa_o` to θ − Δi (mod 1024). Here θ = (adc >> (ADC_W−10)) + RX_BIAS (mod 1024), and Δi is the stored receive offset, which is 0 until calibrated. `rx_drive_o` is 0, so the feedback loop controls the receive delay. `doa_o` changes only on a tick.
- R3: In closed-loop operation the transmit phase commanded on a tick is −P − Δj (mod 1024), where P is the `doa_o` value held before that tick. The transmit output therefore trails the receive report by exactly one tick.
- R4: A receive-calibration start in closed-loop mode freezes `doa_o` and the transmit code. On the CAL_SETTLE-th following tick it latches the current θ as Δi and sets `cal_done_o[0]`.
- R5: A receive-calibration start after `cal_done_o[0]` is set is ignored. Δi never changes again, and reporting continues on the next tick.
- R6: A transmit-calibration start forces `tx_dac_o` to 0 (a 0° command) from the next clock onward. A later `cal_tx_meas_vld_i` loads `cal_tx_meas_i` as Δj and sets `cal_done_o[1]`. This sequence also runs only once.
- R7: In manual mode each tick sets `rx_drive_o` to 1 and `rx_dac_o` to ((man_rx + Δi − RX_BIAS) mod 1024) << (ADC_W−10). It also commands the transmit phase man_tx − Δj. `doa_o` is left unchanged.
- R8: The transmit code for a phase p is floor(p·TX_CODE_NUM / LO_MULT). This accounts for the phase shifter acting on a reference that is multiplied by LO_MULT. At the defaults (96, 24) each phase code step gives 4 DAC codes.
- R9: In closed-loop mode with the carrier absent and extrapolation off, each tick holds `doa_o`. It sets `rx_drive_o` to 1 and drives `rx_dac_o` from the held phase plus Δi.
- R10: With extrapolation on, each dropout tick adds the stored rate to `doa_o`, for at most `extrap_max_i` consecutive ticks, after which the phase holds. The rate is the wrapped difference between the last two consecutive carrier-present samples, or 0 if only one sample was taken since the last dropout.
- R11: Every phase sum, difference and negation wraps modulo 1024, both above 1023 and below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Conversion tick, one clock wide |
| adc_code_i | input | ADC_W | Receive control-voltage code |
| sig_present_i | input | 1 | Received carrier present |
| mode_manual_i | input | 1 | 1 = manual steering, 0 = closed loop |
| extrap_en_i | input | 1 | Extrapolate during dropout |
| extrap_max_i | input | CNT_W | Maximum extrapolation ticks |
| man_rx_ph_i | input | 10 | Manual receive phase |
| man_tx_ph_i | input | 10 | Manual transmit phase |
| cal_rx_start_i | input | 1 | Start receive calibration (pulse) |
| cal_tx_start_i | input | 1 | Start transmit calibration (pulse) |
| cal_tx_meas_vld_i | input | 1 | Measured transmit phase valid |
| cal_tx_meas_i | input | 10 | Measured transmit phase difference |
| rx_dac_o | output | ADC_W | Receive delay DAC code |
| rx_drive_o | output | 1 | 1 = DAC drives receive delay, 0 = feedback |
| tx_dac_o | output | TXD_W | Transmit phase-shifter DAC code |
| doa_o | output | 10 | Reported received relative phase |
| cal_done_o | output | 2 | [0] receive, [1] transmit offset captured |

## Verification
A wrong receive offset or a lookup error shows on `doa_o` on the tick after the sample. The same error reaches `tx_dac_o` one tick later as a negated phase. A corrupted rate register or extrapolation counter stays hidden until a dropout. It then appears as a phase drift of the wrong size, or as drift that runs past the tick limit. A calibration sequence that re-arms, or fails to run, freezes or shifts `doa_o` on the tick after the ignored start.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int PH_W = 10;
  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/pc_rx_map.sv
module pc_rx_map
  import pc_pkg::*;
#(
  parameter int ADC_W   = 12,
  parameter int RX_BIAS = 37
) (
  input  logic [ADC_W-1:0] adc_i,
  output phase_t           theta_o,
  input  phase_t           ph_cmd_i,
  output logic [ADC_W-1:0] dac_o
);
  localparam int SH = ADC_W - PH_W;
  localparam phase_t BIAS = phase_t'(RX_BIAS);

  logic [ADC_W-1:0] adc_sh;
  phase_t           cmd_unb;

  assign adc_sh  = adc_i >> SH;
  assign theta_o = phase_t'(adc_sh) + BIAS;
  assign cmd_unb = ph_cmd_i - BIAS;
  assign dac_o   = ADC_W'(cmd_unb) << SH;
endmodule

// File: rtl/pc_tx_map.sv
module pc_tx_map
  import pc_pkg::*;
#(
  parameter int TXD_W    = 12,
  parameter int LO_MULT  = 24,
  parameter int CODE_NUM = 96
) (
  input  phase_t           ph_i,
  output logic [TXD_W-1:0] code_o
);
  localparam int PROD_W = PH_W + $clog2(CODE_NUM + 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  // reference-side shift is carrier shift divided by the LO multiplier
  assign prod   = PROD_W'(ph_i) * PROD_W'(CODE_NUM);
  assign quot   = prod / PROD_W'(LO_MULT);
  assign code_o = TXD_W'(quot);
endmodule

// File: rtl/pc_cal_seq.sv
module pc_cal_seq
  import pc_pkg::*;
#(
  parameter int CAL_SETTLE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       allow_i,
  input  logic       rx_start_i,
  input  logic       tx_start_i,
  input  phase_t     theta_i,
  input  logic       meas_vld_i,
  input  phase_t     meas_i,
  output phase_t     di_o,
  output phase_t     dj_o,
  output logic       rx_busy_o,
  output logic       tx_busy_o,
  output logic [1:0] done_o
);
  localparam int SW = $clog2(CAL_SETTLE + 1);
  localparam logic [SW-1:0] LAST = SW'(CAL_SETTLE - 1);

  logic [SW-1:0] cnt_q;
  logic          idle;

  assign idle = !rx_busy_o && !tx_busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      di_o      <= '0;
      dj_o      <= '0;
      rx_busy_o <= 1'b0;
      tx_busy_o <= 1'b0;
      done_o    <= '0;
      cnt_q     <= '0;
    end else begin
      if (rx_busy_o && tick_i) begin
        if (cnt_q == LAST) begin
          di_o      <= theta_i;
          rx_busy_o <= 1'b0;
          done_o[0] <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (tx_busy_o && meas_vld_i) begin
        dj_o      <= meas_i;
        tx_busy_o <= 1'b0;
        done_o[1] <= 1'b1;
      end
      if (allow_i && idle) begin
        if (rx_start_i && !done_o[0]) begin
          rx_busy_o <= 1'b1;
          cnt_q     <= '0;
        end else if (tx_start_i && !done_o[1]) begin
          tx_busy_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pc_track.sv
module pc_track
  import pc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             upd_i,
  input  logic             drop_i,
  input  phase_t           meas_i,
  input  logic             extrap_en_i,
  input  logic [CNT_W-1:0] extrap_max_i,
  output phase_t           ph_o,
  output phase_t           ph_nxt_o,
  output logic [CNT_W-1:0] cnt_o
);
  phase_t           rate_q;
  logic             prev_q;
  logic             can_ext;

  assign can_ext = extrap_en_i && (cnt_o < extrap_max_i);

  always_comb begin
    ph_nxt_o = ph_o;
    if (upd_i)                ph_nxt_o = meas_i;
    else if (drop_i && can_ext) ph_nxt_o = ph_o + rate_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_o   <= '0;
      rate_q <= '0;
      prev_q <= 1'b0;
      cnt_o  <= '0;
    end else if (tick_i) begin
      ph_o <= ph_nxt_o;
      if (upd_i) begin
        rate_q <= prev_q ? (meas_i - ph_o) : '0;
        prev_q <= 1'b1;
        cnt_o  <= '0;
      end else if (drop_i) begin
        prev_q <= 1'b0;
        if (can_ext) cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_conj_ctrl.sv
module phase_conj_ctrl
  import pc_pkg::*;
#(
  parameter int ADC_W       = 12,
  parameter int TXD_W       = 12,
  parameter int CNT_W       = 8,
  parameter int RX_BIAS     = 37,
  parameter int LO_MULT     = 24,
  parameter int TX_CODE_NUM = 96,
  parameter int CAL_SETTLE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ADC_W-1:0] adc_code_i,
  input  logic             sig_present_i,
  input  logic             mode_manual_i,
  input  logic             extrap_en_i,
  input  logic [CNT_W-1:0] extrap_max_i,
  input  logic [9:0]       man_rx_ph_i,
  input  logic [9:0]       man_tx_ph_i,
  input  logic             cal_rx_start_i,
  input  logic             cal_tx_start_i,
  input  logic             cal_tx_meas_vld_i,
  input  logic [9:0]       cal_tx_meas_i,
  output logic [ADC_W-1:0] rx_dac_o,
  output logic             rx_drive_o,
  output logic [TXD_W-1:0] tx_dac_o,
  output logic [9:0]       doa_o,
  output logic [1:0]       cal_done_o
);
  phase_t           theta, di, dj, ph_nxt, rx_cmd, tx_ph;
  logic             rx_busy, tx_busy, closed_ok, upd, drop;
  logic [CNT_W-1:0] ext_cnt;
  logic [ADC_W-1:0] rx_dac_d;
  logic [TXD_W-1:0] tx_code;

  assign closed_ok = !mode_manual_i && !rx_busy && !tx_busy;
  assign upd       = closed_ok && sig_present_i;
  assign drop      = closed_ok && !sig_present_i;
  assign rx_cmd    = (mode_manual_i ? phase_t'(man_rx_ph_i) : ph_nxt) + di;
  assign tx_ph     = mode_manual_i ? (phase_t'(man_tx_ph_i) - dj)
                                   : (phase_t'(0) - phase_t'(doa_o) - dj);

  pc_rx_map #(.ADC_W(ADC_W), .RX_BIAS(RX_BIAS)) u_rxm (
    .adc_i(adc_code_i), .theta_o(theta), .ph_cmd_i(rx_cmd), .dac_o(rx_dac_d)
  );

  pc_tx_map #(.TXD_W(TXD_W), .LO_MULT(LO_MULT), .CODE_NUM(TX_CODE_NUM)) u_txm (
    .ph_i(tx_ph), .code_o(tx_code)
  );

  pc_cal_seq #(.CAL_SETTLE(CAL_SETTLE)) u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .allow_i(!mode_manual_i),
    .rx_start_i(cal_rx_start_i), .tx_start_i(cal_tx_start_i), .theta_i(theta),
    .meas_vld_i(cal_tx_meas_vld_i), .meas_i(phase_t'(cal_tx_meas_i)),
    .di_o(di), .dj_o(dj), .rx_busy_o(rx_busy), .tx_busy_o(tx_busy), .done_o(cal_done_o)
  );

  phase_t ph_q;
  pc_track #(.CNT_W(CNT_W)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .upd_i(upd), .drop_i(drop),
    .meas_i(theta - di), .extrap_en_i(extrap_en_i), .extrap_max_i(extrap_max_i),
    .ph_o(ph_q), .ph_nxt_o(ph_nxt), .cnt_o(ext_cnt)
  );
  assign doa_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_dac_o   <= '0;
      rx_drive_o <= 1'b0;
      tx_dac_o   <= '0;
    end else begin
      if (tx_busy)                 tx_dac_o <= '0;
      else if (tick_i && !rx_busy) tx_dac_o <= tx_code;
      if (tick_i) begin
        if (mode_manual_i) begin
          rx_drive_o <= 1'b1;
          rx_dac_o   <= rx_dac_d;
        end else if (rx_busy) begin
          rx_drive_o <= 1'b0;
        end else if (!tx_busy) begin
          rx_drive_o <= !sig_present_i;
          if (!sig_present_i) rx_dac_o <= rx_dac_d;
        end
      end
    end
  end
endmodule

// File: rtl/pc_ctrl_chk.sv
module pc_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             mode_manual_i,
  input logic             sig_present_i,
  input logic             extrap_en_i,
  input logic [CNT_W-1:0] extrap_max_i,
  input logic [CNT_W-1:0] ext_cnt,
  input logic             rx_busy,
  input logic             tx_busy,
  input logic [9:0]       di,
  input logic [9:0]       doa_o,
  input logic             rx_drive_o,
  input logic [1:0]       cal_done_o,
  input logic [11:0]      tx_dac_lo
);
  p_doa_tick_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(doa_o));
  p_feedback_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !mode_manual_i && sig_present_i && !rx_busy && !tx_busy |=> !rx_drive_o);
  p_di_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o[0] |=> $stable(di) && cal_done_o[0]);
  p_tx_zero_cal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |=> tx_dac_lo == '0);
  p_manual_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && mode_manual_i |=> rx_drive_o);
  p_extrap_limit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !mode_manual_i && !sig_present_i && !rx_busy && !tx_busy &&
    (!extrap_en_i || ext_cnt >= extrap_max_i) |=> $stable(doa_o));
endmodule

bind phase_conj_ctrl pc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_manual_i(mode_manual_i),
  .sig_present_i(sig_present_i), .extrap_en_i(extrap_en_i), .extrap_max_i(extrap_max_i),
  .ext_cnt(ext_cnt), .rx_busy(rx_busy), .tx_busy(tx_busy), .di(di), .doa_o(doa_o),
  .rx_drive_o(rx_drive_o), .cal_done_o(cal_done_o), .tx_dac_lo(12'(tx_dac_o))
);

// File: tb/phase_conj_ctrl_tb.sv
module phase_conj_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [11:0] adc = '0;
  logic        sig = 1'b1;
  logic        man = 1'b0;
  logic        xen = 1'b0;
  logic [7:0]  xmax = '0;
  logic [9:0]  mrx = '0, mtx = '0;
  logic        crx = 1'b0, ctx = 1'b0, mvld = 1'b0;
  logic [9:0]  meas = '0;
  logic [11:0] rx_dac, tx_dac;
  logic        rx_drive;
  logic [9:0]  doa;
  logic [1:0]  done;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  int di_m = 0, dj_m = 0;

  always #2 clk = ~clk;

  phase_conj_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .adc_code_i(adc), .sig_present_i(sig),
    .mode_manual_i(man), .extrap_en_i(xen), .extrap_max_i(xmax), .man_rx_ph_i(mrx),
    .man_tx_ph_i(mtx), .cal_rx_start_i(crx), .cal_tx_start_i(ctx),
    .cal_tx_meas_vld_i(mvld), .cal_tx_meas_i(meas), .rx_dac_o(rx_dac),
    .rx_drive_o(rx_drive), .tx_dac_o(tx_dac), .doa_o(doa), .cal_done_o(done)
  );

  function automatic int wrap(int v); return ((v % 1024) + 1024) % 1024; endfunction
  function automatic int theta(int a); return wrap((a >> 2) + 37); endfunction
  function automatic int tcode(int p); return (wrap(p) * 96) / 24; endfunction
  function automatic int rdac(int p); return wrap(p - 37) << 2; endfunction

  task automatic check(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_rx_cal();
    @(negedge clk) crx = 1'b1;
    @(negedge clk) crx = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 doa", doa, 0);
    check("R1 tx", tx_dac, 0);
    check("R1 rxdac", rx_dac, 0);
    check("R1 drive", rx_drive, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_closed();
    adc = 12'd400; sig = 1'b1;
    do_tick();
    check("R2 doa", doa, theta(400));
    check("R2 drive", rx_drive, 0);
    check("R3 lag", tx_dac, tcode(0));
    do_tick();
    check("R3 conj", tx_dac, tcode(-theta(400)));
    repeat (3) @(negedge clk);
    check("R2 no tick", doa, theta(400));
  endtask

  task automatic t_wrap();
    adc = 12'd4000;
    do_tick();
    check("R11 theta wrap", doa, 13);
    do_tick();
    check("R11 tx wrap", tx_dac, tcode(1024 - 13));
  endtask

  task automatic t_rx_cal();
    adc = 12'd800;
    pulse_rx_cal();
    for (int i = 0; i < 3; i++) begin
      do_tick();
      check("R4 frozen", doa, 13);
    end
    do_tick();
    di_m = theta(800);
    check("R4 done", done, 1);
    do_tick();
    check("R4 zero after cal", doa, 0);
  endtask

  task automatic t_once();
    adc = 12'd1000;
    pulse_rx_cal();
    do_tick();
    check("R5 ignored", doa, wrap(theta(1000) - di_m));
    check("R5 done", done, 1);
  endtask

  task automatic t_tx_cal();
    @(negedge clk) ctx = 1'b1;
    @(negedge clk) ctx = 1'b0;
    check("R6 forced zero", tx_dac, 0);
    do_tick();
    check("R6 still zero", tx_dac, 0);
    @(negedge clk) begin meas = 10'd100; mvld = 1'b1; end
    @(negedge clk) mvld = 1'b0;
    dj_m = 100;
    check("R6 done", done, 3);
    do_tick();
    check("R6 R3 conj with dj", tx_dac, tcode(-50 - dj_m));
  endtask

  task automatic t_manual();
    man = 1'b1; mrx = 10'd10; mtx = 10'd101;
    do_tick();
    check("R7 drive", rx_drive, 1);
    check("R7 rxdac", rx_dac, rdac(10 + di_m));
    check("R8 scaled code", tx_dac, 4);
    check("R7 doa kept", doa, 50);
    man = 1'b0;
  endtask

  task automatic t_hold();
    adc = 12'd1000; sig = 1'b1; xen = 1'b0;
    do_tick();
    check("R2 back", rx_drive, 0);
    sig = 1'b0;
    do_tick();
    check("R9 hold", doa, 50);
    check("R9 drive", rx_drive, 1);
    check("R9 rxdac", rx_dac, rdac(50 + di_m));
    do_tick();
    check("R9 hold2", doa, 50);
  endtask

  task automatic t_extrap();
    sig = 1'b1; adc = 12'd1000;
    do_tick();
    adc = 12'd1020;
    do_tick();
    check("R10 sample", doa, 55);
    xen = 1'b1; xmax = 8'd3; sig = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      do_tick();
      check("R10 extrap", doa, (i <= 3) ? 55 + 5 * i : 70);
    end
  endtask

  task automatic t_extrap_wrap();
    sig = 1'b1; adc = 12'd1000;
    do_tick();
    check("R10 single", doa, 50);
    adc = 12'd960;
    do_tick();
    check("R10 down", doa, 40);
    xmax = 8'd7; sig = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      do_tick();
      check("R11 R10 neg wrap", doa, wrap(40 - 10 * ((i <= 7) ? i : 7)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_closed();
    t_wrap();
    t_rx_cal();
    t_once();
    t_tx_cal();
    t_manual();
    t_hold();
    t_extrap();
    t_extrap_wrap();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule